// File: doc/BRIEF.md
# Indexed Receive FIFO Controller

This block keeps the bookkeeping for two independent receive queues that sit in front of a shared message store. When the acceptance filter hands over a frame, it raises a push strobe and names the target queue. The selected queue then reports, through its put index, the slot the frame goes into. Software reads frames at the get index. It hands them back by writing the index of the last element it has consumed, and that write releases every element from the get index through the named slot in one step.

Each queue reports a 32-bit status word that holds its occupancy, both indices and two flags. A per-queue mode input chooses what happens when a frame arrives at a full queue:

- In blocking mode the frame is dropped.
- In overwrite mode the oldest frame is replaced.

Either way a sticky lost flag records the event. Three one-cycle interrupt pulses per queue announce a stored frame, a queue becoming full, and a lost frame. The frame storage itself and the frame contents are outside this block.

Top module: `rxq_index_ctrl`

## Requirements
- R1: After a synchronous reset, every status word is zero and no interrupt pulse is high.
- R2: The status word has this layout: occupancy in bits 7:0, get index in bits 15:8, put index in bits 23:16, full flag in bit 24 (set when occupancy equals DEPTH) and lost flag in bit 25. All other bits read zero.
- R3: A push goes to the queue named by `push_sel` (0 or 1). When that queue has room, its put index advances by one modulo DEPTH and its occupancy grows by one. The other queue is unchanged.
- R4: A valid acknowledge of index k releases every entry from the get index through k. The get index becomes (k+1) mod DEPTH and the occupancy drops by the number of entries released.
- R5: An acknowledge index that is not below DEPTH, or that does not name an occupied entry, changes nothing.
- R6: In blocking mode (`overwrite_en` bit low), a push to a full queue is discarded: both indices and the occupancy stay the same and the lost flag is set.
- R7: In overwrite mode (`overwrite_en` bit high), a push to a full queue advances both the put index and the get index by one, keeps the occupancy at DEPTH and sets the lost flag.
- R8: The lost flag stays set until `lost_clr` for that queue is high. A lost event in the same cycle as the clear leaves the flag set.
- R9: A push and an acknowledge in the same cycle both take effect. The release is applied first, so a push to a full queue that releases entries in the same cycle is stored normally and no frame is lost.
- R10: `irq_new` for a queue pulses for one cycle, one cycle after any push that stored a frame (including an overwrite).
- R11: `irq_full` for a queue pulses for one cycle, one cycle after its occupancy goes from below DEPTH to DEPTH.
- R12: `irq_lost` for a queue pulses for one cycle, one cycle after each push that was discarded or that overwrote the oldest frame.
- R13: Indices wrap from DEPTH-1 to 0, both on advance and when the get index is computed after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Frame accepted by the filter this cycle |
| push_sel | input | SW | Target queue of the push |
| overwrite_en | input | NUM_FIFO | Per-queue overflow mode: 1 overwrites the oldest frame, 0 discards the new frame |
| ack_valid | input | 1 | Acknowledge-index write strobe |
| ack_sel | input | SW | Queue addressed by the acknowledge |
| ack_idx | input | IW | Index of the last element read |
| lost_clr | input | NUM_FIFO | Write-one-to-clear strobe for each lost flag |
| fifo_status | output | NUM_FIFO x 32 | Registered status word of each queue |
| irq_new | output | NUM_FIFO | One-cycle pulse when a frame is stored |
| irq_full | output | NUM_FIFO | One-cycle pulse when a queue becomes full |
| irq_lost | output | NUM_FIFO | One-cycle pulse when a frame is lost |

## Verification
The assertions assume that `push_sel` and `ack_sel` name an existing queue. They also assume at most one push per cycle, so that no more than one new-frame pulse can be high at a time. Finally, they assume that `overwrite_en` is stable while a full-queue push is in flight. The stimulus selects only queues 0 and 1 and issues a single push per cycle. It changes the mode only between operations, never during one. Acknowledge indices are allowed to be out of range or to point at free slots, because ignoring them is part of the required behaviour.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W        = 32;
  localparam int FILL_LSB      = 0;
  localparam int GET_LSB       = 8;
  localparam int PUT_LSB       = 16;
  localparam int FULL_BIT      = 24;
  localparam int LOST_BIT      = 25;
  localparam int FIELD_W       = 8;

  // Assemble one status word from its fields (R2).
  function automatic logic [STAT_W-1:0] pack_status(
    input logic [FIELD_W-1:0] fill,
    input logic [FIELD_W-1:0] get,
    input logic [FIELD_W-1:0] put,
    input logic               full,
    input logic               lost
  );
    logic [STAT_W-1:0] w;
    w = '0;
    w[FILL_LSB +: FIELD_W] = fill;
    w[GET_LSB  +: FIELD_W] = get;
    w[PUT_LSB  +: FIELD_W] = put;
    w[FULL_BIT]            = full;
    w[LOST_BIT]            = lost;
    return w;
  endfunction
endpackage

// File: rtl/rxq_ack_decode.sv
module rxq_ack_decode #(
  parameter int DEPTH = 3,
  parameter int IW    = 2,
  parameter int FW    = 2
) (
  input  logic [IW-1:0] get_idx,
  input  logic [FW-1:0] fill,
  input  logic [IW-1:0] ack_idx,
  output logic          hit,
  output logic [FW-1:0] rel_cnt,
  output logic [IW-1:0] next_get
);
  localparam int CW = ((IW > FW) ? IW : FW) + 2;

  logic [CW-1:0] a_w, g_w, f_w, off;
  logic          in_range;

  always_comb begin
    a_w = CW'(ack_idx);
    g_w = CW'(get_idx);
    f_w = CW'(fill);
    // distance from the oldest entry to the acknowledged slot (R4, R13)
    off = (a_w >= g_w) ? (a_w - g_w) : (a_w + CW'(DEPTH) - g_w);
    in_range = a_w < CW'(DEPTH);
    hit      = in_range && (off < f_w);      // R5
    rel_cnt  = FW'(off + CW'(1));
    next_get = (ack_idx == IW'(DEPTH - 1)) ? '0 : ack_idx + IW'(1);
  end
endmodule

// File: rtl/rxq_channel.sv
module rxq_channel
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int IW    = 2,
  parameter int FW    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              overwrite,
  input  logic              ack_v,
  input  logic [IW-1:0]     ack_idx,
  input  logic              lost_clr,
  output logic [STAT_W-1:0] status,
  output logic              irq_new,
  output logic              irq_full,
  output logic              irq_lost
);
  logic [IW-1:0] get_q, put_q, get_a, get_n, put_n, dec_next;
  logic [FW-1:0] fill_q, fill_a, fill_n, dec_rel;
  logic          lost_q, lost_n;
  logic          dec_hit, hit, room, store, lost_ev, full_rise;

  rxq_ack_decode #(.DEPTH(DEPTH), .IW(IW), .FW(FW)) u_dec (
    .get_idx (get_q),
    .fill    (fill_q),
    .ack_idx (ack_idx),
    .hit     (dec_hit),
    .rel_cnt (dec_rel),
    .next_get(dec_next)
  );

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
    return (v == IW'(DEPTH - 1)) ? '0 : v + IW'(1);
  endfunction

  always_comb begin
    hit    = ack_v && dec_hit;
    // release first, then push sees the freed room (R9)
    fill_a = hit ? fill_q - dec_rel : fill_q;
    get_a  = hit ? dec_next : get_q;
    room   = fill_a < FW'(DEPTH);
    store  = push && (room || overwrite);
    lost_ev = push && !room;
    put_n  = store ? wrap_inc(put_q) : put_q;
    get_n  = (push && !room && overwrite) ? wrap_inc(get_a) : get_a;
    fill_n = (push && room) ? fill_a + FW'(1) : fill_a;
    full_rise = (fill_q != FW'(DEPTH)) && (fill_n == FW'(DEPTH));
    lost_n = (lost_q && !lost_clr) || lost_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      get_q    <= '0;
      put_q    <= '0;
      fill_q   <= '0;
      lost_q   <= 1'b0;
      irq_new  <= 1'b0;
      irq_full <= 1'b0;
      irq_lost <= 1'b0;
    end else begin
      get_q    <= get_n;
      put_q    <= put_n;
      fill_q   <= fill_n;
      lost_q   <= lost_n;
      irq_new  <= store;
      irq_full <= full_rise;
      irq_lost <= lost_ev;
    end
  end

  assign status = pack_status(FIELD_W'(fill_q), FIELD_W'(get_q), FIELD_W'(put_q),
                              fill_q == FW'(DEPTH), lost_q);

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FW'(DEPTH));

  assert_grow_R3: assert property (@(posedge clk) disable iff (rst)
    push && !ack_v && (fill_q < FW'(DEPTH)) |=> fill_q == $past(fill_q) + FW'(1));

  assert_bad_ack_R5: assert property (@(posedge clk) disable iff (rst)
    ack_v && !dec_hit && !push |=> $stable(get_q) && $stable(fill_q) && $stable(put_q));

  assert_locked_drop_R6: assert property (@(posedge clk) disable iff (rst)
    push && !overwrite && !ack_v && (fill_q == FW'(DEPTH))
    |=> $stable(put_q) && $stable(get_q) && lost_q);

  assert_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    push && overwrite && !ack_v && (fill_q == FW'(DEPTH))
    |=> (fill_q == FW'(DEPTH)) && (get_q != $past(get_q)) && lost_q);

  assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    lost_q && !lost_clr |=> lost_q);

  assert_lost_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    irq_lost |-> lost_q);
endmodule

// File: rtl/rxq_index_ctrl.sv
module rxq_index_ctrl
  import rxq_pkg::*;
#(
  parameter  int DEPTH    = 3,
  parameter  int NUM_FIFO = 2,
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW       = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            push_valid,
  input  logic [SW-1:0]                   push_sel,
  input  logic [NUM_FIFO-1:0]             overwrite_en,
  input  logic                            ack_valid,
  input  logic [SW-1:0]                   ack_sel,
  input  logic [IW-1:0]                   ack_idx,
  input  logic [NUM_FIFO-1:0]             lost_clr,
  output logic [NUM_FIFO-1:0][STAT_W-1:0] fifo_status,
  output logic [NUM_FIFO-1:0]             irq_new,
  output logic [NUM_FIFO-1:0]             irq_full,
  output logic [NUM_FIFO-1:0]             irq_lost
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [NUM_FIFO-1:0] push_vec, ack_vec;

  for (genvar f = 0; f < NUM_FIFO; f++) begin : g_ch
    assign push_vec[f] = push_valid && (push_sel == SW'(f));
    assign ack_vec[f]  = ack_valid && (ack_sel == SW'(f));

    rxq_channel #(.DEPTH(DEPTH), .IW(IW), .FW(FW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .push     (push_vec[f]),
      .overwrite(overwrite_en[f]),
      .ack_v    (ack_vec[f]),
      .ack_idx  (ack_idx),
      .lost_clr (lost_clr[f]),
      .status   (fifo_status[f]),
      .irq_new  (irq_new[f]),
      .irq_full (irq_full[f]),
      .irq_lost (irq_lost[f])
    );
  end

  assert_single_new_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_new));

  assert_new_follows_push_R10: assert property (@(posedge clk) disable iff (rst)
    !push_valid |=> irq_new == '0);
endmodule

// File: tb/tb_rxq_index_ctrl.sv
module tb_rxq_index_ctrl;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0;
  logic [0:0] push_sel = '0;
  logic [1:0] overwrite_en = '0;
  logic ack_valid = 1'b0;
  logic [0:0] ack_sel = '0;
  logic [1:0] ack_idx = '0;
  logic [1:0] lost_clr = '0;
  logic [1:0][31:0] fifo_status;
  logic [1:0] irq_new, irq_full, irq_lost;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rxq_index_ctrl #(.DEPTH(D), .NUM_FIFO(2)) dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_sel(push_sel),
    .overwrite_en(overwrite_en), .ack_valid(ack_valid), .ack_sel(ack_sel),
    .ack_idx(ack_idx), .lost_clr(lost_clr), .fifo_status(fifo_status),
    .irq_new(irq_new), .irq_full(irq_full), .irq_lost(irq_lost)
  );

  typedef struct packed {
    logic [1:0][31:0] st;
    logic [1:0] nw;
    logic [1:0] fu;
    logic [1:0] lo;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int mf[2], mg[2], mp[2];
  bit ml[2];

  // monitor: compares one expected item per cycle after the update edge
  always @(posedge clk) begin
    exp_t e;
    string t;
    #5;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (fifo_status !== e.st || irq_new !== e.nw || irq_full !== e.fu || irq_lost !== e.lo) begin
        errors++;
        $display("FAIL %s: status=%h/%h new=%b full=%b lost=%b expected status=%h/%h new=%b full=%b lost=%b",
                 t, fifo_status[1], fifo_status[0], irq_new, irq_full, irq_lost,
                 e.st[1], e.st[0], e.nw, e.fu, e.lo);
      end
    end
  end

  task automatic op(input bit pv, input int ps, input bit av, input int as_,
                    input int ai, input bit [1:0] clr, input string tag);
    exp_t e;
    @(negedge clk);
    push_valid = pv; push_sel = ps[0:0];
    ack_valid = av; ack_sel = as_[0:0]; ack_idx = ai[1:0];
    lost_clr = clr;
    e = '0;
    for (int f = 0; f < 2; f++) begin
      int old_fill;
      bit lev;
      old_fill = mf[f];
      lev = 0;
      if (av && as_ == f && ai < D) begin
        int off;
        off = (ai - mg[f] + D) % D;
        if (off < mf[f]) begin
          mf[f] = mf[f] - (off + 1);
          mg[f] = (ai + 1) % D;
        end
      end
      if (pv && ps == f) begin
        if (mf[f] < D) begin
          mp[f] = (mp[f] + 1) % D; mf[f]++; e.nw[f] = 1'b1;
        end else begin
          lev = 1;
          if (overwrite_en[f]) begin
            mp[f] = (mp[f] + 1) % D; mg[f] = (mg[f] + 1) % D; e.nw[f] = 1'b1;
          end
        end
      end
      ml[f] = (ml[f] && !clr[f]) || lev;
      e.lo[f] = lev;
      e.fu[f] = (old_fill < D) && (mf[f] == D);
      e.st[f] = {6'b0, ml[f], (mf[f] == D), 8'(mp[f]), 8'(mg[f]), 8'(mf[f])};
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    push_valid = 0; ack_valid = 0; lost_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int f = 0; f < 2; f++) begin mf[f] = 0; mg[f] = 0; mp[f] = 0; ml[f] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    checks++;
    if (fifo_status !== '0 || irq_new !== '0 || irq_full !== '0 || irq_lost !== '0) begin
      errors++;
      $display("FAIL R1: status=%h irq=%b%b%b expected all zero",
               fifo_status, irq_new, irq_full, irq_lost);
    end
    op(1, 0, 0, 0, 0, 2'b00, "R2 R3 R10 push q0");
    op(1, 1, 0, 0, 0, 2'b00, "R3 push q1 only");
    op(1, 0, 0, 0, 0, 2'b00, "R3 second push q0");
    op(1, 0, 0, 0, 0, 2'b00, "R11 q0 becomes full");
    op(1, 0, 0, 0, 0, 2'b00, "R6 R12 blocking drop");
    op(0, 0, 1, 0, 3, 2'b00, "R5 ack out of range");
    op(0, 0, 1, 0, 0, 2'b00, "R4 ack single");
    op(0, 0, 1, 0, 0, 2'b00, "R5 ack free slot");
    op(0, 0, 1, 0, 2, 2'b00, "R4 R13 ack two with wrap");
    op(0, 0, 0, 0, 0, 2'b01, "R8 clear lost q0");
    op(1, 0, 0, 0, 0, 2'b00, "R3 refill 1");
    op(1, 0, 0, 0, 0, 2'b00, "R3 refill 2");
    op(1, 0, 0, 0, 0, 2'b00, "R11 R13 refill full put wraps");
    op(1, 0, 1, 0, 0, 2'b00, "R9 push and ack same cycle");
    overwrite_en = 2'b10;
    op(1, 1, 0, 0, 0, 2'b00, "R3 q1 fill");
    op(1, 1, 0, 0, 0, 2'b00, "R11 q1 full");
    op(1, 1, 0, 0, 0, 2'b00, "R7 R12 overwrite");
    op(1, 1, 0, 0, 0, 2'b10, "R8 R7 event beats clear");
    op(0, 0, 0, 0, 0, 2'b10, "R8 clear lost q1");
    op(0, 0, 1, 1, 1, 2'b00, "R4 release whole q1");
    op(1, 0, 1, 1, 0, 2'b00, "R6 R5 drop q0 while q1 empty ack");
    idle();
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule